// File: doc/BRIEF.md
# Packet I2C Master Word Buffer Pair

This block holds the data words that pass between the register bus and the bus engine of a packet-mode I2C master. Software pushes 32-bit words into a transmit queue. The engine drains that queue one word at a time. Going the other way, the engine deposits received words into a receive queue, and software reads them out. Every entry carries four payload bytes. A last word that is only partly used still takes a full entry, and its unused upper bytes are don't-care.

A single control register holds two parts. The first is a trigger threshold for each direction, which sets when that direction's data-request level is raised toward the interrupt logic. The second is a pair of flush bits. Each flush bit is written with a 1, reads back as busy for one cycle, and then clears itself as its queue is emptied. A status word reports the free transmit slots and the filled receive slots as two packed count fields. Two one-cycle error pulses flag misuse: a write to a full transmit queue, and a read from an empty receive queue.

Top module: `i2c_word_buffer`

## Requirements
- R1: After reset both queues are empty, the control register reads 0, the status reads 0x80 (8 free transmit slots, 0 receive words), tx_req is 1 and rx_req, tx_ovf and rx_unf are 0.
- R2: Words written through host_tx_wr are delivered on eng_tx_data in write order, each in the cycle after the eng_tx_pop that removes it.
- R3: Words pushed by the engine are delivered on host_rx_data in push order, each in the cycle after the host_rx_rd that removes it.
- R4: stat_rdata bits 7:4 hold the number of free transmit slots (depth minus fill) and bits 3:0 the number of filled receive slots. Both reflect every operation from the cycle after it.
- R5: A control write stores bits 4:2 as the receive trigger and bits 7:5 as the transmit trigger, and ctl_rdata returns them at the same positions.
- R6: Writing 1 to control bit 0 (receive) or bit 1 (transmit) makes that bit read 1 for exactly one cycle. At the next edge the matching queue is emptied and the bit returns to 0, and any access to that queue in that cycle is discarded. The other queue is not affected.
- R7: A host_tx_wr while the transmit queue holds 8 words drops the word, leaves the queue unchanged, and pulses tx_ovf for one cycle in the next cycle.
- R8: A host_rx_rd while the receive queue is empty returns 0 on host_rx_data, pulses rx_unf for one cycle in the next cycle, and does not move the read position, so the next pushed word is the next one read.
- R9: tx_req is 1 exactly while the free transmit slots exceed the transmit trigger.
- R10: rx_req is 1 exactly while the filled receive slots exceed the receive trigger.
- R11: An engine pop of an empty transmit queue returns 0 without an error pulse. An engine push into a full receive queue is dropped without an error pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write value: flushes in bits 1:0, triggers in bits 7:2 |
| ctl_rdata | output | 8 | Control register readback |
| stat_rdata | output | 8 | Free transmit slots (7:4), filled receive slots (3:0) |
| host_tx_wr | input | 1 | Host writes one transmit word |
| host_tx_data | input | 32 | Transmit word from the host |
| host_rx_rd | input | 1 | Host reads one receive word |
| host_rx_data | output | 32 | Receive word, valid the cycle after host_rx_rd |
| eng_tx_pop | input | 1 | Engine takes one transmit word |
| eng_tx_data | output | 32 | Transmit word, valid the cycle after eng_tx_pop |
| eng_rx_push | input | 1 | Engine stores one receive word |
| eng_rx_data | input | 32 | Receive word from the engine |
| tx_req | output | 1 | Transmit data request level |
| rx_req | output | 1 | Receive data request level |
| tx_ovf | output | 1 | One-cycle pulse: write to full transmit queue |
| rx_unf | output | 1 | One-cycle pulse: read of empty receive queue |

## Verification
The bench drives both queues to full and past full in the same cycle as a pop. A design that let the extra write in would corrupt the oldest word or push the count to nine. It also reads the receive queue while it is empty and then pushes a single word. A design that advanced its read position on the failed read would return stale memory instead of that word. Flushes are requested while traffic is still moving, so an access accepted during the flush cycle, or a flush bit that stays set, shows up as a count mismatch. Trigger values from 0 to 7 are swept against every fill level, which exposes an off-by-one comparison on either request line.

// File: rtl/i2cwb_pkg.sv
package i2cwb_pkg;
  localparam int TRIG_W = 3;
  localparam int CTL_W  = 2 * TRIG_W + 2;

  // packed so that bit 0 is rx flush, 1 tx flush, 4:2 rx trigger, 7:5 tx trigger
  typedef struct packed {
    logic [TRIG_W-1:0] tx_trig;
    logic [TRIG_W-1:0] rx_trig;
    logic              tx_flush;
    logic              rx_flush;
  } buf_ctl_t;
endpackage

// File: rtl/i2cwb_ctl_reg.sv
module i2cwb_ctl_reg
  import i2cwb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output buf_ctl_t         ctl_q
);
  buf_ctl_t wval;
  assign wval = buf_ctl_t'(wdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else begin
      // a flush request lives for one cycle; the queue empties at the next edge
      ctl_q.tx_flush <= wr & wval.tx_flush;
      ctl_q.rx_flush <= wr & wval.rx_flush;
      if (wr) begin
        ctl_q.tx_trig <= wval.tx_trig;
        ctl_q.rx_trig <= wval.rx_trig;
      end
    end
  end

  // R5
  trig_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr |=> ($stable(ctl_q.tx_trig) && $stable(ctl_q.rx_trig)));
  // R6
  flush_once_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.tx_flush && !wr) |=> !ctl_q.tx_flush);
endmodule

// File: rtl/i2cwb_word_fifo.sv
module i2cwb_word_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count_q;
  logic              full, empty, push_ok, pop_ok;

  assign full    = (count_q == CNT_W'(DEPTH));
  assign empty   = (count_q == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign count   = count_q;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (pop) rdata <= pop_ok ? mem[rd_ptr] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push_ok) wr_ptr <= step_ptr(wr_ptr);
      if (pop_ok)  rd_ptr <= step_ptr(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(DEPTH));
  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count_q == '0));
  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> (count_q == CNT_W'(DEPTH)));
  // R8
  empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> (rdata == '0));
endmodule

// File: rtl/i2c_word_buffer.sv
module i2c_word_buffer
  import i2cwb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int CMP_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_wr,
  input  logic [CTL_W-1:0]   ctl_wdata,
  output logic [CTL_W-1:0]   ctl_rdata,
  output logic [2*CNT_W-1:0] stat_rdata,
  input  logic               host_tx_wr,
  input  logic [DATA_W-1:0]  host_tx_data,
  input  logic               host_rx_rd,
  output logic [DATA_W-1:0]  host_rx_data,
  input  logic               eng_tx_pop,
  output logic [DATA_W-1:0]  eng_tx_data,
  input  logic               eng_rx_push,
  input  logic [DATA_W-1:0]  eng_rx_data,
  output logic               tx_req,
  output logic               rx_req,
  output logic               tx_ovf,
  output logic               rx_unf
);
  buf_ctl_t         ctl;
  logic [CNT_W-1:0] tx_cnt, rx_cnt, tx_free;

  i2cwb_ctl_reg u_ctl (
    .clk(clk), .rst(rst), .wr(ctl_wr), .wdata(ctl_wdata), .ctl_q(ctl)
  );

  i2cwb_word_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(ctl.tx_flush),
    .push(host_tx_wr), .wdata(host_tx_data),
    .pop(eng_tx_pop), .rdata(eng_tx_data), .count(tx_cnt)
  );

  i2cwb_word_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(ctl.rx_flush),
    .push(eng_rx_push), .wdata(eng_rx_data),
    .pop(host_rx_rd), .rdata(host_rx_data), .count(rx_cnt)
  );

  assign tx_free    = CNT_W'(DEPTH) - tx_cnt;
  assign ctl_rdata  = ctl;
  assign stat_rdata = {tx_free, rx_cnt};

  // levels come straight from registered counts and trigger fields
  assign tx_req = CMP_W'(tx_free) > CMP_W'(ctl.tx_trig);
  assign rx_req = CMP_W'(rx_cnt)  > CMP_W'(ctl.rx_trig);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_ovf <= 1'b0;
      rx_unf <= 1'b0;
    end else begin
      tx_ovf <= host_tx_wr && (tx_cnt == CNT_W'(DEPTH));
      rx_unf <= host_rx_rd && (rx_cnt == '0);
    end
  end

  // R7
  ovf_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (host_tx_wr && tx_free == '0 && !eng_tx_pop && !ctl.tx_flush)
      |=> (tx_ovf && tx_free == '0));
  // R8
  unf_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rx_rd && rx_cnt == '0) |=> rx_unf);
  // R6
  rx_flush_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.rx_flush |=> (rx_cnt == '0 && !rx_req));
endmodule

// File: tb/tb_i2c_word_buffer.sv
module tb_i2c_word_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int CNT_W = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [7:0]  ctl_rdata;
  logic [7:0]  stat_rdata;
  logic        host_tx_wr = 1'b0;
  logic [31:0] host_tx_data = '0;
  logic        host_rx_rd = 1'b0;
  logic [31:0] host_rx_data;
  logic        eng_tx_pop = 1'b0;
  logic [31:0] eng_tx_data;
  logic        eng_rx_push = 1'b0;
  logic [31:0] eng_rx_data = '0;
  logic        tx_req, rx_req, tx_ovf, rx_unf;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_word_buffer dut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .stat_rdata(stat_rdata),
    .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data),
    .host_rx_rd(host_rx_rd), .host_rx_data(host_rx_data),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .tx_req(tx_req), .rx_req(rx_req), .tx_ovf(tx_ovf), .rx_unf(rx_unf)
  );

  // reference model state
  logic [31:0] txq[$];
  logic [31:0] rxq[$];
  logic [2:0]  m_ttrig = 0, m_rtrig = 0;
  bit          m_tfl = 0, m_rfl = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_stat();
    return {4'(DEPTH - txq.size()), 4'(rxq.size())};
  endfunction

  function automatic logic [7:0] exp_ctl();
    return {m_ttrig, m_rtrig, m_tfl, m_rfl};
  endfunction

  task automatic check_levels();
    chk("R4 status", {24'd0, stat_rdata}, {24'd0, exp_stat()});
    chk("R5 R6 control", {24'd0, ctl_rdata}, {24'd0, exp_ctl()});
    chk("R9 tx_req", {31'd0, tx_req}, {31'd0, (DEPTH - txq.size()) > int'(m_ttrig)});
    chk("R10 rx_req", {31'd0, rx_req}, {31'd0, rxq.size() > int'(m_rtrig)});
  endtask

  // one clock with the inputs currently driven; model updated from pre-edge state
  task automatic step();
    bit e_ovf, e_unf, t_push, t_pop, r_push, r_pop;
    bit chk_t, chk_r;
    logic [31:0] e_tdat, e_rdat;
    e_ovf  = host_tx_wr && txq.size() == DEPTH;
    e_unf  = host_rx_rd && rxq.size() == 0;
    t_push = host_tx_wr && txq.size() < DEPTH && !m_tfl;
    t_pop  = eng_tx_pop && txq.size() > 0 && !m_tfl;
    r_push = eng_rx_push && rxq.size() < DEPTH && !m_rfl;
    r_pop  = host_rx_rd && rxq.size() > 0 && !m_rfl;
    chk_t  = eng_tx_pop;
    chk_r  = host_rx_rd;
    e_tdat = t_pop ? txq[0] : 32'd0;
    e_rdat = r_pop ? rxq[0] : 32'd0;
    if (t_pop) void'(txq.pop_front());
    if (t_push) txq.push_back(host_tx_data);
    if (r_pop) void'(rxq.pop_front());
    if (r_push) rxq.push_back(eng_rx_data);
    if (m_tfl) txq.delete();
    if (m_rfl) rxq.delete();
    m_tfl = ctl_wr && ctl_wdata[1];
    m_rfl = ctl_wr && ctl_wdata[0];
    if (ctl_wr) begin
      m_ttrig = ctl_wdata[7:5];
      m_rtrig = ctl_wdata[4:2];
    end
    @(posedge clk);
    @(negedge clk);
    check_levels();
    chk("R7 tx_ovf", {31'd0, tx_ovf}, {31'd0, e_ovf});
    chk("R8 rx_unf", {31'd0, rx_unf}, {31'd0, e_unf});
    if (chk_t) chk("R2 R11 eng_tx_data", eng_tx_data, e_tdat);
    if (chk_r) chk("R3 R8 host_rx_data", host_rx_data, e_rdat);
  endtask

  task automatic idle();
    ctl_wr = 0; host_tx_wr = 0; host_rx_rd = 0; eng_tx_pop = 0; eng_rx_push = 0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 status", {24'd0, stat_rdata}, 32'h80);
    chk("R1 control", {24'd0, ctl_rdata}, 32'h0);
    chk("R1 req", {30'd0, tx_req, rx_req}, 32'h2);
    chk("R1 pulses", {30'd0, tx_ovf, rx_unf}, 32'h0);

    // R7: nine writes, last overflows; R2 order; R11 pop of empty
    for (int i = 0; i < 9; i++) begin
      idle(); host_tx_wr = 1; host_tx_data = 32'hA000_0000 + i; step();
    end
    idle(); host_tx_wr = 1; eng_tx_pop = 1; host_tx_data = 32'hBEEF_0001; step();
    for (int i = 0; i < 9; i++) begin
      idle(); eng_tx_pop = 1; step();
    end
    // R8: empty read then a single push must come out next
    idle(); host_rx_rd = 1; step();
    idle(); eng_rx_push = 1; eng_rx_data = 32'h1234_5678; step();
    idle(); host_rx_rd = 1; step();
    // R11: overfill receive side from engine
    for (int i = 0; i < 10; i++) begin
      idle(); eng_rx_push = 1; eng_rx_data = 32'hC000_0000 + i; step();
    end
    // R10 / R9 trigger sweep at fixed fill levels
    for (int t = 0; t < 8; t++) begin
      idle(); ctl_wr = 1; ctl_wdata = {3'(t), 3'(7 - t), 2'b00}; step();
      idle(); host_rx_rd = 1; step();
    end
    // R6: flush each side while traffic runs
    idle(); host_tx_wr = 1; host_tx_data = 32'h55; step();
    idle(); ctl_wr = 1; ctl_wdata = 8'h02; eng_rx_push = 1; eng_rx_data = 32'h66; step();
    idle(); host_tx_wr = 1; host_tx_data = 32'h77; step();
    idle(); ctl_wr = 1; ctl_wdata = 8'h01; step();
    idle(); host_rx_rd = 1; step();
    idle(); step();

    // constrained random phases
    for (int i = 0; i < 6000; i++) begin
      int ph;
      int pw, pp;
      ph = (i / 300) % 4;
      pw = (ph == 0) ? 80 : (ph == 1) ? 20 : 50;
      pp = (ph == 0) ? 20 : (ph == 1) ? 80 : 50;
      idle();
      host_tx_wr   = ($urandom % 100) < pw;
      host_tx_data = $urandom;
      eng_tx_pop   = ($urandom % 100) < pp;
      eng_rx_push  = ($urandom % 100) < pw;
      eng_rx_data  = $urandom;
      host_rx_rd   = ($urandom % 100) < pp;
      ctl_wr       = ($urandom % 100) < ((ph == 3) ? 10 : 3);
      ctl_wdata    = 8'($urandom);
      step();
    end
    idle(); step();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule